// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the control and status side of a successive-approximation converter as a processor sees it over its register bus. Software writes one byte-wide control/status register that holds a converter enable, a start bit, an interrupt enable, a completion flag and a three-bit prescaler select. A start request launches a timed conversion. The block times each conversion in system-clock cycles, derived from a power-of-two division of the system clock. When the time is up, it sets the completion flag and drops the start bit. The analog sampling and the result register path lie outside this block.

A start also produces a one-cycle trigger toward the analog front end, carrying the channel-select value present at the moment of the start. This trigger is a fire-and-forget pulse with no ready input and no back-pressure. The analog side must accept it in the cycle it appears. The first conversion after the converter is switched on runs almost twice as long as later ones, so that the analog circuitry has time to settle.

Register layout: bit 7 enable, bit 6 start, bit 5 reads 0, bit 4 completion flag, bit 3 interrupt enable, bits 2:0 prescaler select N.

Top module: `adc_conv_seq`

## Requirements
- R1: While a conversion runs, a register write with bit 6 = 0 and bit 7 = 1 leaves the start bit at 1. The conversion runs to its full length.
- R2: A write with bit 7 = 1 and bit 6 = 1 while the start bit reads 0 begins a conversion. In the cycle the start bit first reads 1, `trig_valid` is high for exactly one cycle and `trig_chan` equals the `chan_sel` value present at that write.
- R3: A conversion lasts P × 2^M system-clock cycles, where M = N for N ≥ 1 and M = 1 for N = 0. The start bit reads 1 for exactly that many cycles after the write edge.
- R4: P = 25 for the first conversion after bit 7 changes from 0 to 1, and P = 13 for every later one. A single write that sets enable and start together counts as a first conversion.
- R5: A write with bit 7 = 0 during a conversion cancels it. The start bit reads 0 from the next cycle, and the completion flag is not set.
- R6: When a conversion completes, the flag (bit 4) becomes 1 in the same cycle that the start bit returns to 0.
- R7: The flag is cleared by a write with bit 4 = 1 or by a one-cycle pulse on `irq_ack`. A write with bit 4 = 0 leaves it set.
- R8: `irq` equals the flag ANDed with the interrupt enable (bit 3).
- R9: After reset, `csr_rd` reads 0x00, and `irq` and `trig_valid` are 0.
- R10: A write with bit 6 = 1 and bit 7 = 0 starts nothing: the start bit stays 0 and no trigger is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Byte written to the control/status register |
| chan_sel | input | 3 | Channel select captured at a start |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| csr_rd | output | 8 | Current register contents |
| trig_valid | output | 1 | One-cycle start trigger |
| trig_chan | output | 3 | Channel carried by the trigger |
| irq | output | 1 | Completion interrupt request |

## Verification
The hardest state to reach from the ports is the long first conversion taken after a disable and re-enable. Reaching it needs a cancelled conversion, then a separate enable-only write, then a start, and the bench runs exactly that sequence. The bench also writes start = 0 partway through a running conversion, and a scoreboard measures how long the start bit stays high. This shows that neither the software clear nor a prescaler rewrite during the run changes the duration that was committed at the start.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CSR_W   = 8;
  localparam int PS_W    = 3;
  localparam int EN_BIT  = 7;
  localparam int GO_BIT  = 6;
  localparam int FLG_BIT = 4;
  localparam int IE_BIT  = 3;
  localparam int PS_LSB  = 0;

  typedef struct packed {
    logic            en;
    logic            go;
    logic            flag;
    logic            ie;
    logic [PS_W-1:0] ps;
  } csr_t;
endpackage

// File: rtl/adc_dur_calc.sv
module adc_dur_calc #(
  parameter int PS_W    = 3,
  parameter int CNT_W   = 12,
  parameter int FIRST_P = 25,
  parameter int NORM_P  = 13
) (
  input  logic             first,
  input  logic [PS_W-1:0]  ps,
  output logic [CNT_W-1:0] dur
);
  logic [PS_W-1:0]  shift;
  logic [CNT_W-1:0] base;

  always_comb begin
    shift = (ps == '0) ? PS_W'(1) : ps;
    base  = first ? CNT_W'(FIRST_P) : CNT_W'(NORM_P);
    dur   = base << shift;
  end
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             cancel,
  input  logic [CNT_W-1:0] load_val,
  output logic             done,
  output logic             running
);
  logic [CNT_W-1:0] cnt_q;

  assign done = running && (cnt_q == CNT_W'(1)) && !cancel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      running <= 1'b0;
    end else if (cancel) begin
      cnt_q   <= '0;
      running <= 1'b0;
    end else if (load) begin
      cnt_q   <= load_val;
      running <= 1'b1;
    end else if (running) begin
      if (cnt_q == CNT_W'(1)) begin
        cnt_q   <= '0;
        running <= 1'b0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/adc_csr.sv
module adc_csr
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  input  logic             conv_done,
  input  logic             irq_ack,
  output csr_t             csr,
  output logic             first_eff,
  output logic             start_pulse,
  output logic             cancel
);
  csr_t csr_q;
  logic first_q;
  logic en_rise;

  assign csr = csr_q;

  always_comb begin
    en_rise     = wr_en && wr_data[EN_BIT] && !csr_q.en;
    first_eff   = first_q || en_rise;
    start_pulse = wr_en && wr_data[EN_BIT] && wr_data[GO_BIT] && !csr_q.go;
    cancel      = wr_en && !wr_data[EN_BIT] && csr_q.en && csr_q.go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q   <= '0;
      first_q <= 1'b0;
    end else begin
      if (wr_en) begin
        csr_q.en <= wr_data[EN_BIT];
        csr_q.ie <= wr_data[IE_BIT];
        csr_q.ps <= wr_data[PS_LSB +: PS_W];
      end

      if (conv_done || cancel)
        csr_q.go <= 1'b0;
      else if (start_pulse)
        csr_q.go <= 1'b1;
      else if (wr_en && !wr_data[EN_BIT])
        csr_q.go <= 1'b0;

      if (en_rise)
        first_q <= 1'b1;
      else if (conv_done)
        first_q <= 1'b0;

      if (conv_done)
        csr_q.flag <= 1'b1;
      else if ((wr_en && wr_data[FLG_BIT]) || irq_ack)
        csr_q.flag <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int CH_W    = 3,
  parameter int FIRST_P = 25,
  parameter int NORM_P  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  input  logic [CH_W-1:0]  chan_sel,
  input  logic             irq_ack,
  output logic [CSR_W-1:0] csr_rd,
  output logic             trig_valid,
  output logic [CH_W-1:0]  trig_chan,
  output logic             irq
);
  localparam int MAX_SHIFT = (1 << PS_W) - 1;
  localparam int CNT_W     = $clog2((FIRST_P << MAX_SHIFT) + 1);

  csr_t             csr;
  logic             first_eff;
  logic             start_pulse;
  logic             conv_cancel;
  logic             conv_done;
  logic             conv_running;
  logic [CNT_W-1:0] conv_dur;

  adc_csr u_csr (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .conv_done   (conv_done),
    .irq_ack     (irq_ack),
    .csr         (csr),
    .first_eff   (first_eff),
    .start_pulse (start_pulse),
    .cancel      (conv_cancel)
  );

  adc_dur_calc #(
    .PS_W    (PS_W),
    .CNT_W   (CNT_W),
    .FIRST_P (FIRST_P),
    .NORM_P  (NORM_P)
  ) u_dur (
    .first (first_eff),
    .ps    (wr_data[PS_LSB +: PS_W]),
    .dur   (conv_dur)
  );

  adc_conv_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_pulse),
    .cancel   (conv_cancel),
    .load_val (conv_dur),
    .done     (conv_done),
    .running  (conv_running)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_valid <= 1'b0;
      trig_chan  <= '0;
    end else begin
      trig_valid <= start_pulse;
      if (start_pulse)
        trig_chan <= chan_sel;
    end
  end

  always_comb begin
    csr_rd                       = '0;
    csr_rd[EN_BIT]               = csr.en;
    csr_rd[GO_BIT]               = csr.go;
    csr_rd[FLG_BIT]              = csr.flag;
    csr_rd[IE_BIT]               = csr.ie;
    csr_rd[PS_LSB +: PS_W]       = csr.ps;
    irq                          = csr.flag && csr.ie;
  end
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk
  import adc_seq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CSR_W-1:0] csr_rd,
  input logic             trig_valid,
  input logic             conv_done,
  input logic             conv_cancel,
  input logic             conv_running
);
  // R1: a running conversion keeps the start bit set unless it ends or is cancelled
  a_r1_go_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd[GO_BIT] && conv_running && !conv_done && !conv_cancel) |=> csr_rd[GO_BIT]);

  // R2: trigger lasts one cycle
  a_r2_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |=> !trig_valid);

  // R2: trigger coincides with the start bit rising
  a_r2_trig_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |-> (csr_rd[GO_BIT] && conv_running));

  // R5: cancel drops the start bit without setting the flag
  a_r5_cancel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_cancel && !csr_rd[FLG_BIT]) |=> (!csr_rd[GO_BIT] && !csr_rd[FLG_BIT]));

  // R6: completion sets the flag and drops the start bit together
  a_r6_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (csr_rd[FLG_BIT] && !csr_rd[GO_BIT]));
endmodule

bind adc_conv_seq adc_conv_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .csr_rd       (csr_rd),
  .trig_valid   (trig_valid),
  .conv_done    (conv_done),
  .conv_cancel  (conv_cancel),
  .conv_running (conv_running)
);

// File: tb/adc_conv_seq_bench.sv
module adc_conv_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] chan_sel = 3'd0;
  logic       irq_ack = 1'b0;
  logic [7:0] csr_rd;
  logic       trig_valid;
  logic [2:0] trig_chan;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done_run = 1'b0;

  typedef struct {
    logic [2:0] chan;
    int         dur;
    bit         cancelled;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  adc_conv_seq u_adc_conv_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .chan_sel   (chan_sel),
    .irq_ack    (irq_ack),
    .csr_rd     (csr_rd),
    .trig_valid (trig_valid),
    .trig_chan  (trig_chan),
    .irq        (irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done_run) begin
      done_run = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  // monitor: measures start-bit duration after each trigger
  bit         mon_active = 1'b0;
  int         mon_cnt = 0;
  logic [2:0] mon_chan = 3'd0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (trig_valid) begin
        mon_active = 1'b1;
        mon_cnt    = 0;
        mon_chan   = trig_chan;
      end
      if (mon_active) begin
        if (csr_rd[6]) mon_cnt++;
        else begin
          exp_t e;
          mon_active = 1'b0;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R2 unexpected trigger", 1, 0);
          end else begin
            e = exp_q.pop_front();
            chk(mon_chan == e.chan, "R2 trig_chan", mon_chan, e.chan);
            if (e.cancelled) begin
              chk(csr_rd[4] == 1'b0, "R5 no flag on cancel", csr_rd[4], 0);
            end else begin
              chk(mon_cnt == e.dur, "R3/R4 duration", mon_cnt, e.dur);
              chk(csr_rd[4] == 1'b1, "R6 flag at completion", csr_rd[4], 1);
            end
          end
        end
      end
    end
  end

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic start(input logic [7:0] v, input logic [2:0] ch, input int dur, input bit canc);
    exp_t e;
    e.chan = ch; e.dur = dur; e.cancelled = canc;
    exp_q.push_back(e);
    chan_sel = ch;
    wr(v);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (csr_rd[6] && n < 5000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(csr_rd == 8'h00, "R9 csr reset", csr_rd, 0);
    chk(irq == 1'b0, "R9 irq reset", irq, 0);
    chk(trig_valid == 1'b0, "R9 trig reset", trig_valid, 0);

    // R4: enable and start in one write -> first conversion, N=0 -> x2
    start(8'hC0, 3'd5, 50, 1'b0);
    wait_idle();
    chk(irq == 1'b0, "R8 irq masked", irq, 0);
    wr(8'h80);
    chk(csr_rd[4] == 1'b1, "R7 write 0 keeps flag", csr_rd[4], 1);
    wr(8'h90);
    chk(csr_rd[4] == 1'b0, "R7 write 1 clears flag", csr_rd[4], 0);

    // R3: N=3 later conversion, interrupt enabled
    start(8'hCB, 3'd2, 104, 1'b0);
    wait_idle();
    chk(irq == 1'b1, "R8 irq raised", irq, 1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk(csr_rd[4] == 1'b0 && irq == 1'b0, "R7 ack clears flag", csr_rd[4], 0);

    // R1: software clear of the start bit is ignored
    start(8'hC2, 3'd7, 52, 1'b0);
    repeat (10) @(negedge clk);
    wr(8'h87);
    chk(csr_rd[6] == 1'b1, "R1 start bit held", csr_rd[6], 1);
    wait_idle();
    wr(8'h90);

    // R3: largest prescaler
    start(8'hC7, 3'd1, 1664, 1'b0);
    wait_idle();
    wr(8'h90);

    // R3: N=1 equals N=0 division
    start(8'hC1, 3'd3, 26, 1'b0);
    wait_idle();
    wr(8'h90);

    // R5: cancel mid-run
    start(8'hC4, 3'd4, 0, 1'b1);
    repeat (20) @(negedge clk);
    wr(8'h04);
    chk(csr_rd[6] == 1'b0, "R5 start bit cleared", csr_rd[6], 0);
    repeat (250) @(negedge clk);
    chk(csr_rd[4] == 1'b0, "R5 flag stays clear", csr_rd[4], 0);

    // R10: start while disabled is ignored
    wr(8'h40);
    chk(csr_rd[6] == 1'b0, "R10 no start when disabled", csr_rd[6], 0);
    chk(trig_valid == 1'b0, "R10 no trigger", trig_valid, 0);

    // R4: separate enable then start -> long first conversion again
    wr(8'h80);
    start(8'hC1, 3'd6, 50, 1'b0);
    wait_idle();
    chk(irq == 1'b0, "R8 irq masked again", irq, 0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all triggers seen", exp_q.size(), 0);
    done_run = 1'b1;
    finish_run();
  end
endmodule